// File: doc/BRIEF.md
# Lockable Crossbar Slave-Port Configuration Register Block

This block is a small bus slave that stores the arbitration settings for each slave port of a crossbar switch. For every slave port it holds a priority word, which gives each master its arbitration level, and a control word, which selects the arbitration mode and carries a write-lock bit. The priority word and the mode of every port leave the block on dedicated outputs and go straight to the per-port arbiters.

Software reaches the registers through a request/acknowledge handshake. The handshake carries an address, a write flag, a supervisor flag and a transfer-size code. An access is carried out only if three things hold: it comes from supervisor mode, it is a 32-bit transfer, and it targets a mapped register. Every access finishes on its second cycle with either an acknowledge or an error. Once a port's lock bit is set, writes to both of that port's registers are rejected with an error, while reads still work. Only reset clears the lock.

Top module: `port_cfg_regs`

## Requirements
- R1: After reset, every priority word reads 0x6543_0210, every control word reads 0x0000_0000, and every port's arbitration mode output is 00.
- R2: With the default parameters, port 0 sits at base 0x100 and port 1 at base 0x400. The priority word is at base+0x00 and the control word at base+0x10. Any other address ends in an error and changes no register.
- R3: A request is captured on the first clock edge at which reqValid is high. Exactly one of ackOut or errOut is high for one cycle, in the second cycle of the access. The two are never high together.
- R4: A request with reqSuper low ends in an error, writes nothing and returns rdata of zero.
- R5: The size code is 00 for byte, 01 for 16-bit, 10 for 32-bit and 11 for a 16-byte burst. Only code 10 is carried out. Every other code ends in an error and has no effect.
- R6: A priority write stores the data ANDed with 0x7777_7777, so bit 3 of each 4-bit level is reserved and reads as zero. The stored word appears on that port's slice of prioWord.
- R7: In the control word, bit 31 is the lock bit and bits 9:8 are the arbitration mode, where 00 means fixed and 01 means round-robin. The mode appears on that port's slice of arbMode. All other control bits read as zero.
- R8: While a port is locked, writes to either of its registers end in an error and change nothing. Reads of that port still acknowledge, and the other port is not affected.
- R9: Once set, a lock bit stays set until reset. A write that clears bit 31 cannot release it.
- R10: rdata is zero in every cycle that does not carry a read acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Access request, held by the master until it sees a response |
| reqAddr | input | 12 | Register-space byte address |
| reqWrite | input | 1 | 1 for a write, 0 for a read |
| reqSuper | input | 1 | 1 when the master is in supervisor mode |
| reqSize | input | 2 | Transfer size code (see R5) |
| reqWdata | input | 32 | Write data |
| ackOut | output | 1 | Access completed normally |
| errOut | output | 1 | Access terminated with a bus error |
| rdata | output | 32 | Read data, valid with ackOut on a read |
| prioWord | output | 64 | Priority word of every port, port i at bits 32i+31:32i |
| arbMode | output | 4 | Arbitration mode of every port, port i at bits 2i+1:2i |

## Verification
The bench goes after the access checks that a careless decoder merges or skips. If the supervisor test or the size test were dropped, a user-mode or byte write would silently change a priority word. If the decoder compared only part of the address, an offset such as base+0x04 would be acknowledged. If the lock were wrong, it would be cleared by writing bit 31 low, or it would block the neighbouring port, or it would block reads. The bench also checks the reserved-bit masking of both words and the exact response cycle. A design that responded in the request cycle, held the response for two cycles, or left read data on the bus after an error would be caught.

// File: rtl/port_cfg_pkg.sv
package port_cfg_pkg;

  localparam int DATA_W = 32;

  // Register reset values and writable-bit masks
  localparam logic [DATA_W-1:0] PRIO_RESET = 32'h6543_0210;
  localparam logic [DATA_W-1:0] PRIO_MASK  = 32'h7777_7777;

  // Control word layout
  localparam int LOCK_BIT = 31;
  localparam int MODE_LO  = 8;
  localparam int MODE_W   = 2;

  // Offset of the control word from a port base
  localparam int CTRL_OFS = 'h10;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'b00,
    SZ_HALF  = 2'b01,
    SZ_WORD  = 2'b10,
    SZ_BURST = 2'b11
  } accSize_e;

  typedef enum logic [1:0] {
    ARB_FIXED = 2'b00,
    ARB_ROUND = 2'b01
  } arbMode_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic capture;  // latch write data of a new request
    logic wrPrio;   // commit priority write
    logic wrCtrl;   // commit control write
    logic rdEn;     // drive read data
    logic isCtrl;   // selected register is the control word
  } dpCtl_t;

endpackage

// File: rtl/port_cfg_ctrl.sv
module port_cfg_ctrl
  import port_cfg_pkg::*;
#(
  parameter int NPORT  = 2,
  parameter int ADDR_W = 12,
  parameter logic [NPORT*ADDR_W-1:0] PORT_BASE = {12'h400, 12'h100},
  localparam int PIDX_W = (NPORT > 1) ? $clog2(NPORT) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqWrite,
  input  logic              reqSuper,
  input  logic [1:0]        reqSize,
  input  logic [NPORT-1:0]  lockVec,
  output dpCtl_t            ctl,
  output logic [PIDX_W-1:0] portIdx,
  output logic              ackOut,
  output logic              errOut
);

  localparam logic [ADDR_W-1:0] CTRL_OFS_A = ADDR_W'(CTRL_OFS);

  typedef enum logic {ST_IDLE = 1'b0, ST_RESP = 1'b1} accState_e;

  accState_e        state;
  logic [ADDR_W-1:0] addrQ;
  logic              writeQ;
  logic              superQ;
  logic [1:0]        sizeQ;

  logic [NPORT-1:0]  hitPrio;
  logic [NPORT-1:0]  hitCtrl;
  logic              mapped;
  logic              isCtrl;
  logic              attrOk;
  logic              lockHit;
  logic              allowed;
  logic              inResp;
  logic              startReq;

  assign startReq = (state == ST_IDLE) && reqValid;

  // Request capture and two-cycle sequencing
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      addrQ  <= '0;
      writeQ <= 1'b0;
      superQ <= 1'b0;
      sizeQ  <= SZ_BYTE;
    end else begin
      case (state)
        ST_IDLE: begin
          if (reqValid) begin
            state  <= ST_RESP;
            addrQ  <= reqAddr;
            writeQ <= reqWrite;
            superQ <= reqSuper;
            sizeQ  <= reqSize;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // Per-port address comparators
  for (genvar gi = 0; gi < NPORT; gi++) begin : g_dec
    localparam logic [ADDR_W-1:0] BASE = PORT_BASE[gi*ADDR_W +: ADDR_W];
    assign hitPrio[gi] = (addrQ == BASE);
    assign hitCtrl[gi] = (addrQ == BASE + CTRL_OFS_A);
  end

  always_comb begin
    portIdx = '0;
    for (int i = 0; i < NPORT; i++) begin
      if (hitPrio[i] || hitCtrl[i]) portIdx = PIDX_W'(i);
    end
  end

  assign mapped  = |(hitPrio | hitCtrl);
  assign isCtrl  = |hitCtrl;
  assign attrOk  = superQ && (sizeQ == SZ_WORD);
  assign lockHit = lockVec[portIdx];
  assign allowed = mapped && attrOk && !(writeQ && lockHit);
  assign inResp  = (state == ST_RESP);

  assign ackOut = inResp && allowed;
  assign errOut = inResp && !allowed;

  always_comb begin
    ctl         = '0;
    ctl.capture = startReq;
    ctl.isCtrl  = isCtrl;
    ctl.wrPrio  = inResp && allowed && writeQ && !isCtrl;
    ctl.wrCtrl  = inResp && allowed && writeQ && isCtrl;
    ctl.rdEn    = inResp && allowed && !writeQ;
  end

endmodule

// File: rtl/port_cfg_dp.sv
module port_cfg_dp
  import port_cfg_pkg::*;
#(
  parameter int NPORT = 2,
  localparam int PIDX_W = (NPORT > 1) ? $clog2(NPORT) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  dpCtl_t                  ctl,
  input  logic [PIDX_W-1:0]       portIdx,
  input  logic [DATA_W-1:0]       reqWdata,
  output logic [DATA_W-1:0]       rdata,
  output logic [NPORT*DATA_W-1:0] prioWord,
  output logic [NPORT*MODE_W-1:0] arbMode,
  output logic [NPORT-1:0]        lockVec
);

  logic [DATA_W-1:0] wdataQ;
  logic [DATA_W-1:0] prioQ [NPORT];
  logic [MODE_W-1:0] modeQ [NPORT];
  logic [NPORT-1:0]  lockQ;
  logic [DATA_W-1:0] ctrlWord [NPORT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wdataQ <= '0;
    else if (ctl.capture) wdataQ <= reqWdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NPORT; i++) begin
        prioQ[i] <= PRIO_RESET;
        modeQ[i] <= ARB_FIXED;
      end
      lockQ <= '0;
    end else begin
      for (int i = 0; i < NPORT; i++) begin
        if (portIdx == PIDX_W'(i)) begin
          if (ctl.wrPrio) prioQ[i] <= wdataQ & PRIO_MASK;
          if (ctl.wrCtrl) begin
            modeQ[i] <= wdataQ[MODE_LO +: MODE_W];
            lockQ[i] <= lockQ[i] | wdataQ[LOCK_BIT];
          end
        end
      end
    end
  end

  for (genvar gi = 0; gi < NPORT; gi++) begin : g_out
    always_comb begin
      ctrlWord[gi] = '0;
      ctrlWord[gi][LOCK_BIT] = lockQ[gi];
      ctrlWord[gi][MODE_LO +: MODE_W] = modeQ[gi];
    end
    assign prioWord[gi*DATA_W +: DATA_W] = prioQ[gi];
    assign arbMode[gi*MODE_W +: MODE_W]  = modeQ[gi];
  end

  assign lockVec = lockQ;

  always_comb begin
    rdata = '0;
    if (ctl.rdEn) rdata = ctl.isCtrl ? ctrlWord[portIdx] : prioQ[portIdx];
  end

endmodule

// File: rtl/port_cfg_regs.sv
module port_cfg_regs
  import port_cfg_pkg::*;
#(
  parameter int NPORT  = 2,
  parameter int ADDR_W = 12,
  parameter logic [NPORT*ADDR_W-1:0] PORT_BASE = {12'h400, 12'h100}
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    reqValid,
  input  logic [ADDR_W-1:0]       reqAddr,
  input  logic                    reqWrite,
  input  logic                    reqSuper,
  input  logic [1:0]              reqSize,
  input  logic [DATA_W-1:0]       reqWdata,
  output logic                    ackOut,
  output logic                    errOut,
  output logic [DATA_W-1:0]       rdata,
  output logic [NPORT*DATA_W-1:0] prioWord,
  output logic [NPORT*MODE_W-1:0] arbMode
);

  localparam int PIDX_W = (NPORT > 1) ? $clog2(NPORT) : 1;

  dpCtl_t            ctl;
  logic [PIDX_W-1:0] portIdx;
  logic [NPORT-1:0]  lockVec;

  port_cfg_ctrl #(
    .NPORT(NPORT), .ADDR_W(ADDR_W), .PORT_BASE(PORT_BASE)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqWrite(reqWrite), .reqSuper(reqSuper), .reqSize(reqSize),
    .lockVec(lockVec), .ctl(ctl), .portIdx(portIdx),
    .ackOut(ackOut), .errOut(errOut)
  );

  port_cfg_dp #(.NPORT(NPORT)) u_dp (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .portIdx(portIdx),
    .reqWdata(reqWdata), .rdata(rdata), .prioWord(prioWord),
    .arbMode(arbMode), .lockVec(lockVec)
  );

endmodule

// File: rtl/port_cfg_chk.sv
module port_cfg_chk #(
  parameter int NPORT = 2
) (
  input logic                clk,
  input logic                rst_n,
  input logic                reqValid,
  input logic                ackOut,
  input logic                errOut,
  input logic [31:0]         rdata,
  input logic [NPORT*32-1:0] prioWord,
  input logic [NPORT*2-1:0]  arbMode,
  input logic [NPORT-1:0]    lockVec
);

  // R3
  ack_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ackOut && errOut));

  // R3
  resp_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ackOut || errOut) |=> !(ackOut || errOut));

  // R3
  resp_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ackOut || errOut) |-> $past(reqValid));

  // R10
  rdata_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ackOut |-> (rdata == '0));

  for (genvar gi = 0; gi < NPORT; gi++) begin : g_port
    // R9
    lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(lockVec[gi]) |-> lockVec[gi]);

    // R8
    locked_prio_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lockVec[gi] && $past(lockVec[gi])) |-> $stable(prioWord[gi*32 +: 32]));

    // R8
    locked_mode_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lockVec[gi] && $past(lockVec[gi])) |-> $stable(arbMode[gi*2 +: 2]));
  end

endmodule

bind port_cfg_regs port_cfg_chk #(.NPORT(NPORT)) u_chk (
  .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .ackOut(ackOut),
  .errOut(errOut), .rdata(rdata), .prioWord(prioWord),
  .arbMode(arbMode), .lockVec(lockVec)
);

// File: tb/sim_port_cfg_regs.sv
`timescale 1ns/1ps
module sim_port_cfg_regs;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reqValid = 1'b0;
  logic [11:0] reqAddr = '0;
  logic        reqWrite = 1'b0;
  logic        reqSuper = 1'b0;
  logic [1:0]  reqSize = 2'b00;
  logic [31:0] reqWdata = '0;
  logic        ackOut, errOut;
  logic [31:0] rdata;
  logic [63:0] prioWord;
  logic [3:0]  arbMode;

  int nChecks = 0;
  int nErr = 0;
  bit done = 0;

  // Reference model state
  logic [31:0] prioM [2];
  logic [1:0]  modeM [2];
  bit          lockM [2];
  bit          modelOn = 0;

  always #10 clk = ~clk;

  port_cfg_regs u0 (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqWrite(reqWrite), .reqSuper(reqSuper), .reqSize(reqSize),
    .reqWdata(reqWdata), .ackOut(ackOut), .errOut(errOut), .rdata(rdata),
    .prioWord(prioWord), .arbMode(arbMode)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] ctrlM(input int p);
    logic [31:0] w = '0;
    w[31] = lockM[p];
    w[9:8] = modeM[p];
    return w;
  endfunction

  // Every clock: arbiter-facing outputs follow the model (R1, R6, R7)
  always @(negedge clk) begin
    if (rst_n && modelOn) begin
      for (int p = 0; p < 2; p++) begin
        chk(prioWord[p*32 +: 32] == prioM[p], "R6 prioWord slice",
            prioWord[p*32 +: 32], prioM[p]);
        chk(arbMode[p*2 +: 2] == modeM[p], "R7 arbMode slice",
            {30'b0, arbMode[p*2 +: 2]}, {30'b0, modeM[p]});
      end
    end
  end

  task automatic access(input logic [11:0] a, input bit wr, input bit sup,
                        input logic [1:0] sz, input logic [31:0] wd,
                        input string tag);
    int  port = -1;
    bit  isC = 0;
    bit  ok;
    logic [31:0] expRd = '0;
    if (a == 12'h100) begin port = 0; isC = 0; end
    if (a == 12'h110) begin port = 0; isC = 1; end
    if (a == 12'h400) begin port = 1; isC = 0; end
    if (a == 12'h410) begin port = 1; isC = 1; end
    ok = (port >= 0) && sup && (sz == 2'b10) && !(wr && lockM[port]);
    if (ok && !wr) expRd = isC ? ctrlM(port) : prioM[port];

    @(negedge clk);
    reqValid = 1'b1; reqAddr = a; reqWrite = wr; reqSuper = sup;
    reqSize = sz; reqWdata = wd;
    #1;
    chk(!ackOut && !errOut, {"R3 no response in request cycle ", tag},
        {30'b0, ackOut, errOut}, 32'd0);
    @(negedge clk);
    chk(ackOut == ok, {tag, " ack"}, {31'b0, ackOut}, {31'b0, ok});
    chk(errOut == !ok, {"R3 ", tag, " err"}, {31'b0, errOut}, {31'b0, !ok});
    chk(rdata == expRd, {"R10 ", tag, " rdata"}, rdata, expRd);
    reqValid = 1'b0;
    @(posedge clk);
    #1;
    if (ok && wr) begin
      if (isC) begin
        modeM[port] = wd[9:8];
        lockM[port] = lockM[port] | wd[31];
      end else begin
        prioM[port] = wd & 32'h7777_7777;
      end
    end
    @(negedge clk);
    chk(!ackOut && !errOut, {"R3 single-cycle response ", tag},
        {30'b0, ackOut, errOut}, 32'd0);
  endtask

  initial begin
    for (int p = 0; p < 2; p++) begin
      prioM[p] = 32'h6543_0210; modeM[p] = 2'b00; lockM[p] = 0;
    end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    modelOn = 1;
    @(negedge clk);
    chk(!ackOut && !errOut && rdata == 0, "R1 idle outputs after reset",
        {30'b0, ackOut, errOut}, 32'd0);
    chk(prioWord[31:0] == 32'h6543_0210, "R1 reset prio port0",
        prioWord[31:0], 32'h6543_0210);
    chk(arbMode == 4'b0000, "R1 reset mode", {28'b0, arbMode}, 32'd0);

    // R1 reset values by read
    access(12'h100, 0, 1, 2'b10, 0, "R1 read prio0");
    access(12'h410, 0, 1, 2'b10, 0, "R1 read ctrl1");
    // R6 masking
    access(12'h100, 1, 1, 2'b10, 32'hFFFF_FFFF, "R6 write prio0");
    access(12'h100, 0, 1, 2'b10, 0, "R6 read prio0");
    access(12'h400, 1, 1, 2'b10, 32'h1234_5678, "R6 write prio1");
    access(12'h400, 0, 1, 2'b10, 0, "R6 read prio1");
    // R7 control layout
    access(12'h410, 1, 1, 2'b10, 32'h0000_0100, "R7 round-robin port1");
    access(12'h410, 0, 1, 2'b10, 0, "R7 read ctrl1");
    access(12'h410, 1, 1, 2'b10, 32'h7FFF_FEFF, "R7 reserved bits ctrl1");
    access(12'h410, 0, 1, 2'b10, 0, "R7 readback ctrl1");
    // R4 user mode
    access(12'h100, 1, 0, 2'b10, 32'h0, "R4 user write prio0");
    access(12'h110, 0, 0, 2'b10, 0, "R4 user read ctrl0");
    access(12'h100, 0, 1, 2'b10, 0, "R4 prio0 unchanged");
    // R5 sizes
    access(12'h100, 1, 1, 2'b00, 32'h0, "R5 byte write");
    access(12'h100, 1, 1, 2'b01, 32'h0, "R5 half write");
    access(12'h110, 1, 1, 2'b11, 32'h8000_0000, "R5 burst write");
    access(12'h400, 0, 1, 2'b00, 0, "R5 byte read");
    access(12'h110, 0, 1, 2'b10, 0, "R5 ctrl0 unchanged");
    // R2 unmapped
    access(12'h104, 1, 1, 2'b10, 32'h0, "R2 offset 0x04");
    access(12'h120, 0, 1, 2'b10, 0, "R2 offset 0x20");
    access(12'h200, 1, 1, 2'b10, 32'h0, "R2 no port at 0x200");
    access(12'h000, 0, 1, 2'b10, 0, "R2 address 0");
    // R8/R9 lock on port0
    access(12'h110, 1, 1, 2'b10, 32'h8000_0100, "R8 set lock port0");
    access(12'h100, 1, 1, 2'b10, 32'h0, "R8 locked prio0 write");
    access(12'h110, 1, 1, 2'b10, 32'h0, "R9 clear lock attempt");
    access(12'h110, 0, 1, 2'b10, 0, "R9 lock still set");
    access(12'h100, 0, 1, 2'b10, 0, "R8 locked read prio0");
    access(12'h400, 1, 1, 2'b10, 32'h0765_4321, "R8 port1 still writable");
    access(12'h400, 0, 1, 2'b10, 0, "R8 port1 readback");
    chk(prioWord[31:0] == 32'h7777_7777, "R8 prio0 held",
        prioWord[31:0], 32'h7777_7777);

    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", nErr, nChecks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      nChecks++;
      nErr++;
      $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
      $display("Result: errors=%0d of %0d checks", nErr, nChecks);
      $finish;
    end
  end

endmodule